// File: doc/BRIEF.md
# Configuration Memory Scrub Controller

This block looks after the configuration memory of an FPGA that works under radiation. A golden image sits in non-volatile flash, split into equal frames. The controller copies those frames into the configuration memory through a frame-addressed port that can write and read single words. The logic that the configuration memory implements keeps running the whole time.

A host chooses one of three jobs with a 2-bit mode code and starts it with a start pulse. Mode 0 (load) writes every frame once and then reports done. Mode 1 (scrub) rewrites every frame, wraps from the last frame back to frame 0, and keeps going until the host asks it to stop. Mode 2 (verify) reads each frame back one word at a time and compares each word with the golden copy. At the first word that differs it stops comparing, rewrites only that frame, counts one error, and moves on to the next frame. Mode code 3 is reserved. The host reads an error counter, which saturates at all ones and is cleared only by the host's clear pulse.

The state machine runs through these states:

- IDLE: leaves to FETCH on start with a valid mode.
- FETCH: loads one golden frame into a local buffer, then goes to WRITE in load or scrub mode, or to READ in verify mode.
- WRITE: goes to ADVANCE after the last word.
- READ: goes to CMP.
- CMP: goes back to READ for the next word, to REWRITE on a mismatch, or to ADVANCE after the last word matches.
- REWRITE: goes to ADVANCE after the last word.
- ADVANCE: goes to FETCH for the next frame, wraps to frame 0 in scrub mode, goes to IDLE with done after the last frame, or goes to IDLE without done when a stop is pending.

Top module: `cfg_scrub_ctrl`

## Requirements
- R1: During and after reset, with no start given, busy, done and the error count are 0, and no flash or configuration port request is raised.
- R2: Mode code 0 writes word k of frame f with golden word f*FRAME_WORDS+k, covering every frame in order. It then raises done with busy low and leaves the error count unchanged. Done and busy are never both high.
- R3: Mode code 1 writes every frame, wraps from the last frame back to frame 0, and continues without ever raising done.
- R4: A stop pulse takes effect only at a frame boundary. Configuration writes always run word 0 to word FRAME_WORDS-1 in consecutive cycles, and busy falls only after the last word of a frame has been written. Done stays low after a stop.
- R5: Mode code 2 reads every frame back, writes nothing to frames that match, and rewrites with golden data every frame that differs. The configuration memory then equals the golden image and done is raised.
- R6: A differing frame adds exactly one to the error count, however many of its words differ. No word of that frame beyond the first differing word is read before the rewrite.
- R7: The error count saturates at 2^ERR_W-1 and stays there on further errors.
- R8: A host clear pulse sets the error count to 0. If a new error is detected in the same cycle as the clear, the count becomes 1.
- R9: A start pulse with mode code 3 is ignored: busy stays low and no request is raised.
- R10: A flash read of word k of frame f uses address f*FRAME_WORDS+k, and its data is taken one cycle after the request. A configuration read returns data one cycle after the request. At most one of the three requests is active in any cycle.
- R11: A valid start clears done and raises busy in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 2 | Mode code: 0 load, 1 scrub, 2 verify, 3 reserved |
| host_start | input | 1 | Start pulse, sampled only while idle |
| host_stop | input | 1 | Stop pulse, honoured at the next frame boundary |
| host_err_clr | input | 1 | Clears the error count |
| host_busy | output | 1 | A job is running |
| host_done | output | 1 | A load or verify job completed |
| host_err_count | output | ERR_W | Saturating count of frames found in error |
| flash_rd_en | output | 1 | Flash word read request |
| flash_addr | output | FL_AW | Flash word address |
| flash_rd_data | input | DATA_W | Flash data, valid one cycle after the request |
| cfg_wr_en | output | 1 | Configuration word write |
| cfg_rd_en | output | 1 | Configuration word read request |
| cfg_frame | output | FR_W | Frame index on the configuration port |
| cfg_word | output | WD_W | Word index within the frame |
| cfg_wr_data | output | DATA_W | Configuration write data |
| cfg_rd_data | input | DATA_W | Configuration read data, valid one cycle after the request |

## Verification
Two error-count updates can fall in the same cycle: the increment from a failed compare and the host's clear pulse. The bench catches this case by watching the port for the read of a corrupted word. It then drives the clear pulse during the following cycle, which is the compare cycle. Its behavioural model predicts the count on every clock from the read traffic it has observed and from the clear input, and expects 1 rather than 0. A second case is a stop pulse that arrives in the middle of a frame write in scrub mode. The bench judges it by the unbroken word sequence on the port and by the index of the last word written before busy falls.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_READ,
        ST_CMP,
        ST_REWRITE,
        ST_ADVANCE
    } scrub_state_e;

    typedef enum logic [1:0] {
        MODE_LOAD   = 2'd0,
        MODE_SCRUB  = 2'd1,
        MODE_VERIFY = 2'd2,
        MODE_RSVD   = 2'd3
    } scrub_mode_e;

endpackage

// File: rtl/scrub_frame_buf.sv
// Holds one golden frame between the flash fetch and the port accesses.
module scrub_frame_buf #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/scrub_err_cnt.sv
// Saturating frame-error counter; a clear that coincides with an error leaves 1.
module scrub_err_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= W'(inc);
        end else if (inc && cnt_q != MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
    import cfg_scrub_pkg::*;
#(
    parameter int N_FRAMES    = 16,
    parameter int FRAME_WORDS = 8,
    parameter int DATA_W      = 32,
    parameter int ERR_W       = 16,
    localparam int FR_W  = $clog2(N_FRAMES),
    localparam int WD_W  = $clog2(FRAME_WORDS),
    localparam int FL_AW = $clog2(N_FRAMES * FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_mode,
    input  logic              host_start,
    input  logic              host_stop,
    input  logic              host_err_clr,
    output logic              host_busy,
    output logic              host_done,
    output logic [ERR_W-1:0]  host_err_count,
    output logic              flash_rd_en,
    output logic [FL_AW-1:0]  flash_addr,
    input  logic [DATA_W-1:0] flash_rd_data,
    output logic              cfg_wr_en,
    output logic              cfg_rd_en,
    output logic [FR_W-1:0]   cfg_frame,
    output logic [WD_W-1:0]   cfg_word,
    output logic [DATA_W-1:0] cfg_wr_data,
    input  logic [DATA_W-1:0] cfg_rd_data
);
    localparam int CNT_W = $clog2(FRAME_WORDS + 1);
    localparam logic [CNT_W-1:0] FETCH_END  = CNT_W'(FRAME_WORDS);
    localparam logic [CNT_W-1:0] LAST_WORD  = CNT_W'(FRAME_WORDS - 1);
    localparam logic [FR_W-1:0]  LAST_FRAME = FR_W'(N_FRAMES - 1);

    scrub_state_e      state_q, state_d;
    scrub_mode_e       mode_q, mode_d;
    logic [FR_W-1:0]   frame_q, frame_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              done_q, done_d;
    logic              stop_q, stop_d;
    logic              err_inc;
    logic              buf_we;
    logic [DATA_W-1:0] gold_word;

    // Next-state and job bookkeeping
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        frame_d = frame_q;
        cnt_d   = cnt_q;
        done_d  = done_q;
        stop_d  = stop_q | (host_stop && state_q != ST_IDLE);
        err_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                stop_d = 1'b0;
                if (host_start && host_mode != MODE_RSVD) begin
                    mode_d  = scrub_mode_e'(host_mode);
                    frame_d = '0;
                    cnt_d   = '0;
                    done_d  = 1'b0;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (cnt_q == FETCH_END) begin
                    cnt_d   = '0;
                    state_d = (mode_q == MODE_VERIFY) ? ST_READ : ST_WRITE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WRITE, ST_REWRITE: begin
                if (cnt_q == LAST_WORD) begin
                    cnt_d   = '0;
                    state_d = ST_ADVANCE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READ: begin
                state_d = ST_CMP;
            end
            ST_CMP: begin
                if (cfg_rd_data != gold_word) begin
                    err_inc = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_REWRITE;
                end else if (cnt_q == LAST_WORD) begin
                    cnt_d   = '0;
                    state_d = ST_ADVANCE;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                    state_d = ST_READ;
                end
            end
            ST_ADVANCE: begin
                if (stop_q || host_stop) begin
                    state_d = ST_IDLE;
                end else if (frame_q == LAST_FRAME) begin
                    if (mode_q == MODE_SCRUB) begin
                        frame_d = '0;
                        state_d = ST_FETCH;
                    end else begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end else begin
                    frame_d = frame_q + 1'b1;
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_LOAD;
            frame_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            frame_q <= frame_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
            stop_q  <= stop_d;
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        host_busy   = (state_q != ST_IDLE);
        host_done   = done_q;
        flash_rd_en = (state_q == ST_FETCH) && (cnt_q != FETCH_END);
        cfg_wr_en   = (state_q == ST_WRITE) || (state_q == ST_REWRITE);
        cfg_rd_en   = (state_q == ST_READ);
        buf_we      = (state_q == ST_FETCH) && (cnt_q != '0);
    end

    assign flash_addr  = FL_AW'(frame_q) * FL_AW'(FRAME_WORDS) + FL_AW'(cnt_q);
    assign cfg_frame   = frame_q;
    assign cfg_word    = WD_W'(cnt_q);
    assign cfg_wr_data = gold_word;

    scrub_frame_buf #(
        .WORDS  (FRAME_WORDS),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (WD_W'(cnt_q - 1'b1)),
        .wr_data (flash_rd_data),
        .rd_idx  (WD_W'(cnt_q)),
        .rd_data (gold_word)
    );

    scrub_err_cnt #(
        .W (ERR_W)
    ) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_inc),
        .clr   (host_err_clr),
        .count (host_err_count)
    );
endmodule

// File: rtl/cfg_scrub_chk.sv
module cfg_scrub_chk #(
    parameter int ERR_W = 16,
    parameter int WD_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       host_mode,
    input logic             host_start,
    input logic             host_err_clr,
    input logic             host_busy,
    input logic             host_done,
    input logic [ERR_W-1:0] host_err_count,
    input logic             flash_rd_en,
    input logic             cfg_wr_en,
    input logic             cfg_rd_en,
    input logic [WD_W-1:0]  cfg_word
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> !(flash_rd_en || cfg_wr_en || cfg_rd_en)); // R1

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> !host_busy); // R2

    AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_word != '0) |-> ($past(cfg_wr_en) && cfg_word == WD_W'($past(cfg_word) + 1'b1))); // R4

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !host_err_clr |=> (host_err_count == $past(host_err_count) ||
                           host_err_count == ERR_W'($past(host_err_count) + 1'b1))); // R6

    AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err_count == ERR_MAX && !host_err_clr) |=> host_err_count == ERR_MAX); // R7

    AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_clr |=> host_err_count <= ERR_W'(1)); // R8

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy && host_start && host_mode == 2'd3) |=> !host_busy); // R9

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_rd_en, cfg_wr_en, cfg_rd_en})); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy && host_start && host_mode != 2'd3) |=> (host_busy && !host_done)); // R11
endmodule

bind cfg_scrub_ctrl cfg_scrub_chk #(
    .ERR_W (ERR_W),
    .WD_W  (WD_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_mode      (host_mode),
    .host_start     (host_start),
    .host_err_clr   (host_err_clr),
    .host_busy      (host_busy),
    .host_done      (host_done),
    .host_err_count (host_err_count),
    .flash_rd_en    (flash_rd_en),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_rd_en      (cfg_rd_en),
    .cfg_word       (cfg_word)
);

// File: tb/cfg_scrub_ctrl_bench.sv
module cfg_scrub_ctrl_bench;
    localparam int F    = 8;
    localparam int W    = 4;
    localparam int DW   = 32;
    localparam int EW   = 4;
    localparam int FRW  = $clog2(F);
    localparam int WDW  = $clog2(W);
    localparam int FLAW = $clog2(F * W);
    localparam int EMAX = (1 << EW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      host_mode = 2'd0;
    logic            host_start = 1'b0;
    logic            host_stop = 1'b0;
    logic            host_err_clr = 1'b0;
    logic            host_busy, host_done;
    logic [EW-1:0]   host_err_count;
    logic            flash_rd_en, cfg_wr_en, cfg_rd_en;
    logic [FLAW-1:0] flash_addr;
    logic [DW-1:0]   flash_rd_data, cfg_wr_data, cfg_rd_data;
    logic [FRW-1:0]  cfg_frame;
    logic [WDW-1:0]  cfg_word;

    always #4 clk = ~clk;

    cfg_scrub_ctrl #(
        .N_FRAMES (F), .FRAME_WORDS (W), .DATA_W (DW), .ERR_W (EW)
    ) u_cfg_scrub_ctrl (
        .clk (clk), .rst_n (rst_n), .host_mode (host_mode), .host_start (host_start),
        .host_stop (host_stop), .host_err_clr (host_err_clr), .host_busy (host_busy),
        .host_done (host_done), .host_err_count (host_err_count),
        .flash_rd_en (flash_rd_en), .flash_addr (flash_addr), .flash_rd_data (flash_rd_data),
        .cfg_wr_en (cfg_wr_en), .cfg_rd_en (cfg_rd_en), .cfg_frame (cfg_frame),
        .cfg_word (cfg_word), .cfg_wr_data (cfg_wr_data), .cfg_rd_data (cfg_rd_data)
    );

    // Behavioural memories: golden flash image and configuration memory
    logic [DW-1:0] gold [F*W];
    logic [DW-1:0] cmem [F*W];
    bit            bad_frame [F];
    int            first_bad [F];

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_rd = 0, run_mode = 0;
    int exp_err = 0;
    bit pend_mis = 1'b0;
    int last_wr_word = W - 1, last_wr_frame = 0;
    bit saw_wrap = 1'b0, prev_busy = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (flash_rd_en) flash_rd_data <= gold[flash_addr];
        if (cfg_rd_en) cfg_rd_data <= cmem[int'(cfg_frame) * W + int'(cfg_word)];
        if (cfg_wr_en) cmem[int'(cfg_frame) * W + int'(cfg_word)] <= cfg_wr_data;
    end

    // Reference model and per-clock port checks
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_err  = 0;
            pend_mis = 1'b0;
        end else begin
            automatic int idx = int'(cfg_frame) * W + int'(cfg_word);
            automatic bit inc = pend_mis;
            check(int'(host_err_count) == exp_err, "R6/R7/R8 err count", host_err_count, exp_err);
            check(!(host_done && host_busy), "R2 done with busy", {host_done, host_busy}, 2'b10);
            pend_mis = cfg_rd_en && (cmem[idx] != gold[idx]);
            if (host_err_clr) exp_err = inc ? 1 : 0;
            else if (inc && exp_err < EMAX) exp_err++;
            if (flash_rd_en)
                check(int'(flash_addr) / W == int'(cfg_frame), "R10 flash addr", flash_addr, int'(cfg_frame) * W);
            if (cfg_rd_en) begin
                n_rd++;
                if (run_mode == 2 && bad_frame[cfg_frame])
                    check(int'(cfg_word) <= first_bad[cfg_frame], "R6 read past mismatch", cfg_word, first_bad[cfg_frame]);
            end
            if (cfg_wr_en) begin
                n_wr++;
                check(cfg_wr_data == gold[idx], "R2 write data", cfg_wr_data, gold[idx]);
                if (cfg_word != '0)
                    check(int'(cfg_word) == last_wr_word + 1, "R4 word order", cfg_word, last_wr_word + 1);
                if (run_mode == 2)
                    check(bad_frame[cfg_frame], "R5 write to clean frame", cfg_frame, 0);
                if (cfg_word == '0 && int'(cfg_frame) == 0 && last_wr_frame == F - 1) saw_wrap = 1'b1;
                last_wr_word  = int'(cfg_word);
                last_wr_frame = int'(cfg_frame);
            end
            if (prev_busy && !host_busy)
                check(last_wr_word == W - 1, "R4 busy fell mid-frame", last_wr_word, W - 1);
            prev_busy = host_busy;
        end
    end

    task automatic start_run(input int m);
        n_wr = 0; n_rd = 0; run_mode = m; saw_wrap = 1'b0;
        last_wr_word = W - 1; last_wr_frame = 0;
        @(posedge clk); #2;
        host_mode = 2'(m); host_start = 1'b1;
        @(posedge clk); #2;
        host_start = 1'b0;
        check(host_busy && !host_done, "R11 start", {host_busy, host_done}, 2'b10);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!host_busy) break;
        end
    endtask

    task automatic corrupt(input int f, input int k);
        cmem[f * W + k] = cmem[f * W + k] ^ 32'h0000_0100;
        if (!bad_frame[f] || k < first_bad[f]) first_bad[f] = k;
        bad_frame[f] = 1'b1;
    endtask

    task automatic clear_marks();
        for (int f = 0; f < F; f++) begin bad_frame[f] = 1'b0; first_bad[f] = W; end
    endtask

    task automatic image_ok(input string req);
        automatic int bad = 0;
        for (int i = 0; i < F * W; i++) if (cmem[i] != gold[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < F * W; i++) begin
            gold[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0203);
            cmem[i] = '0;
        end
        clear_marks();
        repeat (4) @(posedge clk);
        #2;
        check(!host_busy && !host_done && host_err_count == 0, "R1 reset status",
              {host_busy, host_done, host_err_count}, 0);
        check(!flash_rd_en && !cfg_wr_en && !cfg_rd_en, "R1 reset requests",
              {flash_rd_en, cfg_wr_en, cfg_rd_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(!host_busy && !cfg_wr_en, "R1 quiet after reset", host_busy, 0);

        // Load mode
        start_run(0);
        wait_idle();
        check(host_done && !host_busy, "R2 load done", {host_done, host_busy}, 2'b10);
        check(n_wr == F * W, "R2 load writes", n_wr, F * W);
        check(host_err_count == 0, "R2 load err", host_err_count, 0);
        image_ok("R2 image after load");

        // Verify on a clean image
        start_run(2);
        wait_idle();
        check(n_wr == 0, "R5 clean verify writes", n_wr, 0);
        check(n_rd == F * W, "R5 clean verify reads", n_rd, F * W);
        check(host_done, "R5 verify done", host_done, 1);

        // Verify with upsets: frame 1 has two bad words, frames 5 and 7 one each
        corrupt(1, 2); corrupt(1, 3); corrupt(5, 0); corrupt(7, 3);
        start_run(2);
        wait_idle();
        check(host_err_count == 3, "R6 one error per frame", host_err_count, 3);
        check(n_wr == 3 * W, "R5 repair writes", n_wr, 3 * W);
        check(n_rd == 5 * W + 3 + 1 + 4, "R6 reads stop at mismatch", n_rd, 5 * W + 8);
        image_ok("R5 image repaired");
        clear_marks();

        // Clear while idle
        @(posedge clk); #2; host_err_clr = 1'b1;
        @(posedge clk); #2; host_err_clr = 1'b0;
        @(negedge clk);
        check(host_err_count == 0, "R8 clear", host_err_count, 0);

        // Clear coinciding with a detected error
        corrupt(0, 0); corrupt(2, 1); corrupt(3, 0);
        start_run(2);
        while (!(cfg_rd_en && cfg_frame == 3'd3)) @(negedge clk);
        @(posedge clk); #2; host_err_clr = 1'b1;
        @(posedge clk); #2; host_err_clr = 1'b0;
        wait_idle();
        check(host_err_count == 1, "R8 clear with increment", host_err_count, 1);
        clear_marks();

        // Saturation
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < F; f++) corrupt(f, f % W);
            start_run(2);
            wait_idle();
            clear_marks();
        end
        check(host_err_count == EMAX, "R7 saturation", host_err_count, EMAX);
        image_ok("R5 image after saturation runs");

        // Reserved mode code
        @(posedge clk); #2; host_mode = 2'd3; host_start = 1'b1;
        @(posedge clk); #2; host_start = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(!host_busy && !flash_rd_en && !cfg_wr_en, "R9 reserved ignored", host_busy, 0);

        // Scrub with wrap, then a stop in the middle of a frame
        corrupt(3, 1);
        start_run(1);
        while (!(saw_wrap && n_wr >= F * W + 2 * W)) @(negedge clk);
        check(host_busy && !host_done, "R3 scrub keeps running", {host_busy, host_done}, 2'b10);
        check(saw_wrap, "R3 wrap to frame 0", saw_wrap, 1);
        while (!(cfg_wr_en && cfg_word == 2'd1)) @(negedge clk);
        @(posedge clk); #2; host_stop = 1'b1;
        @(posedge clk); #2; host_stop = 1'b0;
        check(host_busy, "R4 stop waits for frame end", host_busy, 1);
        wait_idle();
        check(n_wr % W == 0, "R4 whole frames", n_wr % W, 0);
        check(!host_done, "R4 no done after stop", host_done, 0);
        check(host_err_count == EMAX, "R3 scrub leaves count", host_err_count, EMAX);
        image_ok("R3 image after scrub");
        clear_marks();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule